// File: doc/BRIEF.md
# Serial Frame Sync Generator

This block produces the transmit frame synchronization pulse for a synchronous serial port. It takes two candidate bit clocks, each presented as a one-cycle strobe in the core clock domain: one from a general-purpose pin and one from the receive side. A 2-bit field picks one of them. The selected bit strobe is counted down by the fixed 16-bit word length and then by a 4-bit frame rate divider. The result marks a frame start every 16 × (rate + 1) bit periods, and a registered sync pulse begins at each frame start.

A mode bit sets the pulse width. In bit mode the pulse lasts one bit period. In word mode it lasts one full word. A second 2-bit field chooses the framing signal the transmitter actually uses: the receive-side frame sync, the internal pulse, or a framing input from an external pin. When the internal pulse is chosen, it is also offered for driving out on the second general-purpose pin, together with an output enable. Divider and mode settings are captured only at frame starts, so software may rewrite them at any time without producing a short or stretched frame.

Top module: `frame_sync_gen`

## Requirements
- R1: While rst_n is low at a clock edge, int_fsync is low after that edge. The first selected bit strobe after reset release starts a frame, and int_fsync is high after that edge.
- R2: clk_sel equal to 2'b10 selects pin_bit_tick as the bit strobe; every other clk_sel value selects rx_bit_tick. The strobe that is not selected has no effect on int_fsync.
- R3: Frame starts are 16 × (rate_div + 1) selected bit strobes apart, where rate_div is the value captured at the earlier frame start. A rate_div of 0 therefore gives one frame every 16 bits, and 15 gives one frame every 256 bits.
- R4: With word_mode = 0 captured at a frame start, int_fsync is high for exactly one selected bit period: it rises on the frame-start strobe and falls on the next selected strobe.
- R5: With word_mode = 1 captured at a frame start, int_fsync stays high for the first 16 selected bit strobes of the frame. If rate_div is 0 in this mode, int_fsync stays high continuously.
- R6: rate_div and word_mode are sampled only on the frame-start strobe. A change in the middle of a frame affects neither the current frame length nor the current pulse width.
- R7: int_fsync is registered and changes only on a clock edge at which the selected bit strobe is high.
- R8: tx_fsync follows fs_src_sel combinationally. Values 2'b00 and 2'b01 pass rx_fsync, 2'b10 passes int_fsync, and 2'b11 passes pin_fsync_in.
- R9: pin_fsync_out always equals int_fsync. pin_fsync_oe is high exactly when fs_src_sel is 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state is updated on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_bit_tick | input | 1 | Bit-clock strobe from the general-purpose pin |
| rx_bit_tick | input | 1 | Bit-clock strobe from the receive side |
| clk_sel | input | 2 | Bit-clock source select (2'b10 selects the pin strobe) |
| rate_div | input | 4 | Frame rate divider; frame length is 16 × (rate_div + 1) bits |
| word_mode | input | 1 | 0 gives a one-bit pulse, 1 gives a one-word pulse |
| fs_src_sel | input | 2 | Transmit framing source select |
| rx_fsync | input | 1 | Receive-side frame sync |
| pin_fsync_in | input | 1 | Framing input from the external pin |
| int_fsync | output | 1 | Internally generated frame sync pulse |
| tx_fsync | output | 1 | Framing signal used by the transmitter |
| pin_fsync_out | output | 1 | Internal pulse offered for the framing pin |
| pin_fsync_oe | output | 1 | Output enable for the framing pin |

## Verification
A wrong bit or word count, or a lost pending-start flag, shows first as a pulse edge at the wrong selected strobe. The first frame start after reset exposes it at once, and any later frame exposes it within one frame length: at most 256 selected strobes. A divider or mode value captured at the wrong time shows as a frame of the wrong length, or a pulse of the wrong width, in the frame that follows the change. Faults in the source selectors appear in the same cycle on tx_fsync, pin_fsync_oe or the pulse timing, because the bench compares every output after every clock edge.

// File: rtl/fsg_pkg.sv
// Shared constants and select encodings for the frame sync generator.
// Assumes: select fields are exactly 2 bits wide.
package fsg_pkg;

    // Bit-clock source select value that picks the pin strobe
    localparam logic [1:0] CLK_SEL_PIN = 2'b10;

    // Transmit framing source encodings
    typedef enum logic [1:0] {
        FS_SRC_RX_A = 2'b00,
        FS_SRC_RX_B = 2'b01,
        FS_SRC_INT  = 2'b10,
        FS_SRC_PIN  = 2'b11
    } fs_src_e;

endpackage

// File: rtl/fsg_tick_sel.sv
// Bit-clock source selector.
// Picks one of two bit-rate strobes, both already synchronous to clk.
// Assumes: each strobe is high for a single clk cycle per bit period.
module fsg_tick_sel
    import fsg_pkg::*;
(
    input  logic       pin_tick,
    input  logic       rx_tick,
    input  logic [1:0] sel,
    output logic       bit_tick
);

    // Choose the pin strobe only for the pin-clock code; otherwise the receive strobe
    always_comb begin
        if (sel == CLK_SEL_PIN) bit_tick = pin_tick;
        else                    bit_tick = rx_tick;
    end

endmodule

// File: rtl/fsg_frame_counter.sv
// Two-stage divider: a fixed word-length bit counter followed by a
// programmable word counter. Reports the frame-start strobe.
// Assumes: WORD_BITS >= 2; rate value is captured only at frame starts.
module fsg_frame_counter #(
    parameter int WORD_BITS = 16,
    parameter int RATE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate_div,
    output logic              frame_start,
    output logic              first_word_hold
);

    localparam int BW = $clog2(WORD_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_BITS - 1);

    logic [BW-1:0]     bit_cnt;
    logic [RATE_W-1:0] word_cnt;
    logic [RATE_W-1:0] active_div;
    logic              start_pending;
    logic              frame_last;

    // Last bit of the last word of the running frame
    always_comb frame_last = (bit_cnt == LAST_BIT) && (word_cnt == active_div);

    // A frame starts on the first strobe after reset or after the last bit
    always_comb frame_start = tick && (start_pending || frame_last);

    // The next non-start strobe still falls inside word zero
    always_comb first_word_hold = (word_cnt == '0) && (bit_cnt != LAST_BIT);

    // Bit and word counting; capture the divider at each frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt       <= '0;
            word_cnt      <= '0;
            active_div    <= '0;
            start_pending <= 1'b1;
        end else if (frame_start) begin
            bit_cnt       <= '0;
            word_cnt      <= '0;
            active_div    <= rate_div;
            start_pending <= 1'b0;
        end else if (tick) begin
            if (bit_cnt == LAST_BIT) begin
                bit_cnt  <= '0;
                word_cnt <= word_cnt + 1'b1;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // R3: the word counter never runs past the captured divider
    a_r3_word_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !start_pending |-> (word_cnt <= active_div));

    // R6: the captured divider only moves on a frame start
    a_r6_div_held: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(active_div));

endmodule

// File: rtl/fsg_pulse_shaper.sv
// Registers the frame sync pulse in bit or word width.
// Assumes: frame_start and first_word_hold come from the frame counter
// and are meaningful only while tick is high.
module fsg_pulse_shaper (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic frame_start,
    input  logic first_word_hold,
    input  logic word_mode,
    output logic fsync
);

    logic mode_q;

    // Raise on frame start; in word mode hold through word zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsync  <= 1'b0;
            mode_q <= 1'b0;
        end else if (frame_start) begin
            fsync  <= 1'b1;
            mode_q <= word_mode;
        end else if (tick) begin
            fsync <= mode_q && first_word_hold;
        end
    end

    // R1: reset clears the pulse
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> !fsync);

    // R7: the pulse is frozen between selected strobes
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(fsync));

    // R4: in bit mode a high pulse drops on the next non-start strobe
    a_r4_bit_width: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && !mode_q && tick && !frame_start) |=> !fsync);

endmodule

// File: rtl/fsg_frame_mux.sv
// Transmit framing source selector and framing pin drive.
// Assumes: all inputs are synchronous to the same clock.
module fsg_frame_mux
    import fsg_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       rx_fs,
    input  logic       int_fs,
    input  logic       pin_fs,
    output logic       tx_fs,
    output logic       pin_oe
);

    // Route the chosen framing source to the transmitter
    always_comb begin
        unique case (fs_src_e'(sel))
            FS_SRC_INT: tx_fs = int_fs;
            FS_SRC_PIN: tx_fs = pin_fs;
            default:    tx_fs = rx_fs;
        endcase
    end

    // Drive the framing pin only when the internal pulse is in use
    always_comb pin_oe = (sel == FS_SRC_INT);

endmodule

// File: rtl/frame_sync_gen.sv
// Frame sync generator top: source select, word and frame dividers,
// pulse shaping and transmit framing selection.
// Assumes: bit clocks arrive as single-cycle strobes synchronous to clk.
module frame_sync_gen #(
    parameter int WORD_BITS = 16,
    parameter int RATE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_bit_tick,
    input  logic              rx_bit_tick,
    input  logic [1:0]        clk_sel,
    input  logic [RATE_W-1:0] rate_div,
    input  logic              word_mode,
    input  logic [1:0]        fs_src_sel,
    input  logic              rx_fsync,
    input  logic              pin_fsync_in,
    output logic              int_fsync,
    output logic              tx_fsync,
    output logic              pin_fsync_out,
    output logic              pin_fsync_oe
);

    logic bit_tick;
    logic frame_start;
    logic first_word_hold;

    fsg_tick_sel u_tick_sel (
        .pin_tick (pin_bit_tick),
        .rx_tick  (rx_bit_tick),
        .sel      (clk_sel),
        .bit_tick (bit_tick)
    );

    fsg_frame_counter #(
        .WORD_BITS (WORD_BITS),
        .RATE_W    (RATE_W)
    ) u_counter (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick            (bit_tick),
        .rate_div        (rate_div),
        .frame_start     (frame_start),
        .first_word_hold (first_word_hold)
    );

    fsg_pulse_shaper u_shaper (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick            (bit_tick),
        .frame_start     (frame_start),
        .first_word_hold (first_word_hold),
        .word_mode       (word_mode),
        .fsync           (int_fsync)
    );

    fsg_frame_mux u_mux (
        .sel    (fs_src_sel),
        .rx_fs  (rx_fsync),
        .int_fs (int_fsync),
        .pin_fs (pin_fsync_in),
        .tx_fs  (tx_fsync),
        .pin_oe (pin_fsync_oe)
    );

    // The framing pin always carries the internal pulse
    always_comb pin_fsync_out = int_fsync;

    // R9: when the pin is enabled the transmitter sees what the pin drives
    a_r9_oe_match: assert property (@(posedge clk) disable iff (!rst_n)
        pin_fsync_oe |-> (tx_fsync == pin_fsync_out));

    // R2: without the selected strobe the pulse cannot change
    a_r2_sel_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_sel == 2'b10) ? !pin_bit_tick : !rx_bit_tick) |=> $stable(int_fsync));

endmodule

// File: tb/tb_frame_sync_gen.sv
module tb_frame_sync_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pin_bit_tick, rx_bit_tick;
    logic [1:0] clk_sel;
    logic [3:0] rate_div;
    logic       word_mode;
    logic [1:0] fs_src_sel;
    logic       rx_fsync, pin_fsync_in;
    logic       int_fsync, tx_fsync, pin_fsync_out, pin_fsync_oe;

    int checks = 0;
    int errors = 0;

    // Reference state, built from the requirements
    bit m_pend;
    int m_k;
    int m_len;
    bit m_wm;
    bit m_fs;

    always #2 clk = ~clk;

    frame_sync_gen dut (
        .clk(clk), .rst_n(rst_n),
        .pin_bit_tick(pin_bit_tick), .rx_bit_tick(rx_bit_tick),
        .clk_sel(clk_sel), .rate_div(rate_div), .word_mode(word_mode),
        .fs_src_sel(fs_src_sel), .rx_fsync(rx_fsync), .pin_fsync_in(pin_fsync_in),
        .int_fsync(int_fsync), .tx_fsync(tx_fsync),
        .pin_fsync_out(pin_fsync_out), .pin_fsync_oe(pin_fsync_oe)
    );

    function automatic bit exp_tx(logic [1:0] s, bit rx, bit in_fs, bit pin);
        if (s == 2'b10) return in_fs;
        if (s == 2'b11) return pin;
        return rx;
    endfunction

    function automatic bit sel_tick(logic [1:0] s, bit p, bit r);
        return (s == 2'b10) ? p : r;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Update the reference on one clock edge with the inputs then applied
    task automatic model_edge();
        if (!rst_n) begin
            m_pend = 1; m_k = 0; m_fs = 0; m_wm = 0; m_len = 16;
        end else if (sel_tick(clk_sel, pin_bit_tick, rx_bit_tick)) begin
            if (m_pend || m_k == m_len - 1) begin
                m_pend = 0; m_k = 0;
                m_len = 16 * (int'(rate_div) + 1);
                m_wm = word_mode;
                m_fs = 1;
            end else begin
                m_k++;
                m_fs = m_wm && (m_k < 16);
            end
        end
    endtask

    // One cycle: inputs already set at the falling edge, then edge, then compare
    task automatic step(string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(req, int_fsync, m_fs);
        check("R8", tx_fsync, exp_tx(fs_src_sel, rx_fsync, m_fs, pin_fsync_in));
        check("R9", pin_fsync_out, m_fs);
        check("R9", pin_fsync_oe, fs_src_sel == 2'b10);
    endtask

    task automatic do_reset();
        rst_n = 0; pin_bit_tick = 0; rx_bit_tick = 0;
        step("R1");
        step("R1");
        rst_n = 1;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        int last_start;
        int gap;
        seed_init = $urandom(32'd20240611);
        clk_sel = 2'b00; rate_div = 4'd0; word_mode = 0; fs_src_sel = 2'b10;
        rx_fsync = 0; pin_fsync_in = 0; pin_bit_tick = 0; rx_bit_tick = 0;
        rst_n = 0;
        @(negedge clk);
        do_reset();
        check("R1", int_fsync, 0);

        // R1: first selected strobe after reset starts a frame
        rx_bit_tick = 1;
        step("R1");
        check("R1", int_fsync, 1);

        // R3/R4: rate 0 bit mode, strobe every cycle, period 16
        last_start = 0;
        gap = 0;
        for (int i = 1; i <= 40; i++) begin
            step("R4");
            if (int_fsync) begin
                gap = i - last_start;
                last_start = i;
            end
        end
        check("R3", gap, 16);

        // R3: rate 15 gives a 256-bit frame (captured at the next start)
        rate_div = 4'd15;
        last_start = -1;
        gap = 0;
        for (int i = 0; i < 600; i++) begin
            step("R3");
            if (int_fsync) begin
                if (last_start >= 0) gap = i - last_start;
                last_start = i;
            end
        end
        check("R3", gap, 256);

        // R5: word mode with rate 0 stays high
        rate_div = 4'd0; word_mode = 1;
        for (int i = 0; i < 300; i++) step("R5");
        check("R5", int_fsync, 1);

        // R2: pin clock selected, receive strobe toggling is ignored
        clk_sel = 2'b10; rx_bit_tick = 1; pin_bit_tick = 0; word_mode = 0;
        for (int i = 0; i < 20; i++) step("R2");
        check("R2", int_fsync, m_fs);

        // R8: every framing source code
        for (int s = 0; s < 4; s++) begin
            fs_src_sel = 2'(s);
            rx_fsync = 1; pin_fsync_in = 0;
            step("R8");
            rx_fsync = 0; pin_fsync_in = 1;
            step("R8");
        end

        // Random phase with mid-frame config changes (R6, R7)
        for (int i = 0; i < 20000; i++) begin
            pin_bit_tick = ($urandom % 3) == 0;
            rx_bit_tick  = ($urandom % 2) == 0;
            rx_fsync     = $urandom % 2;
            pin_fsync_in = $urandom % 2;
            if (($urandom % 50) == 0) rate_div = 4'($urandom % 4);
            if (($urandom % 70) == 0) word_mode = $urandom % 2;
            if (($urandom % 200) == 0) clk_sel = 2'($urandom);
            if (($urandom % 30) == 0) fs_src_sel = 2'($urandom);
            if (($urandom % 3000) == 0) do_reset();
            step("R6/R7");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule